// File: doc/BRIEF.md
# Real-Time Clock Interrupt Controller

This block holds the control and status registers of a PC-style real-time clock and produces the clock's interrupt request. A host reaches the registers in two steps. It first writes an index, then reads or writes the data port. The calendar counter and the battery-backed RAM sit elsewhere. They feed this block an update-in-progress level, an alarm-match strobe and an update-ended strobe. The block also takes a one-cycle tick strobe at 32.768 kHz.

From a 4-bit rate code, the block derives a periodic event with a power-of-two interval counted in ticks. Three flags are kept in the status register: periodic, alarm and update-ended. Each flag is set by its own event whether or not its enable is set. A summary bit is raised when any flag is set together with its enable bit, and the interrupt output follows the summary bit. A read of the status register returns the flags and clears them.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, the registers at index 0xA, 0xB and 0xC read 0x00 while `upd_busy` is low, index 0xD reads 0x80, and `irq` is low.
- R2: A data write at index 0xA stores bits 6:0. Bits 6:4 select the divider and bits 3:0 select the rate. On a read, bit 7 reflects the `upd_busy` input, and the written bit 7 is ignored.
- R3: A data write at index 0xB stores all eight bits, which read back unchanged. Bit 6 enables the periodic interrupt, bit 5 enables the alarm interrupt and bit 4 enables the update-ended interrupt. No other access changes this register.
- R4: The periodic flag (index 0xC bit 6) is set after the following number of ticks, counted from the last write at index 0xA: 2^(code-1) ticks for rate codes 3 to 15, and 128 or 256 ticks for codes 1 and 2. This holds when the divider field is 010. The count then restarts.
- R5: No periodic flag is raised while the divider field differs from 010 or the rate code is 0.
- R6: An `alarm_hit` strobe sets bit 5 of index 0xC and an `update_done` strobe sets bit 4, regardless of the enables.
- R7: Bit 7 of index 0xC and `irq` go high at the clock edge after a cycle in which any flag and its enable in index 0xB are both 1. This includes an enable written after its flag was set.
- R8: A data read at index 0xC returns the flags with bits 3:0 as zero, and it clears all flags and `irq` at that clock edge.
- R9: A flag event that arrives in the same cycle as a clearing read of index 0xC survives, and the next read of index 0xC shows it.
- R10: Data writes at index 0xC and 0xD have no effect. Index 0xD always reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| upd_busy | input | 1 | Calendar update-in-progress level |
| alarm_hit | input | 1 | Alarm match strobe |
| update_done | input | 1 | Update-ended strobe |
| idx_wr | input | 1 | Load the index from `wdata[3:0]` |
| data_wr | input | 1 | Write `wdata` to the indexed register |
| data_rd | input | 1 | Read strobe for the indexed register (clears flags at index 0xC) |
| wdata | input | 8 | Write data and index |
| rdata | output | 8 | Indexed register contents |
| irq | output | 1 | Interrupt request |

## Verification
The bench counts ticks at the edges of the shortest, the odd low-code and the longest rate setting. A divider off by one tick would raise the periodic flag one tick early or late. A design that ignored the divider field would raise flags with the divider disabled. The bench also sets a flag before its enable, to catch a design that only raises the interrupt on the set event. It fires an alarm in the very cycle of a clearing read, where a clear-wins design would lose the event for good. Finally, it writes to the read-only locations, to catch a design that decodes them as storage.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  localparam logic [3:0] IDX_CTL_A  = 4'hA;
  localparam logic [3:0] IDX_CTL_B  = 4'hB;
  localparam logic [3:0] IDX_STAT   = 4'hC;
  localparam logic [3:0] IDX_PWR    = 4'hD;

  localparam logic [2:0] DIV_RUN_32K = 3'b010;
  localparam logic [7:0] PWR_OK_VAL  = 8'h80;

  // flag vector layout: matches status bits 6:4
  localparam int FLG_PER = 2;
  localparam int FLG_ALM = 1;
  localparam int FLG_UPD = 0;

  // ticks between periodic events for a rate code (0 = off)
  function automatic int unsigned rate_ticks(input logic [3:0] code);
    int unsigned c;
    c = int'(code);
    if (c == 0)
      return 0;
    else if (c < 3)
      return 32'd1 << (c + 6);
    else
      return 32'd1 << (c - 1);
  endfunction

endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div
  import rtc_irq_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic       tick,
  input  logic [3:0] code,
  output logic       per_evt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last    = CNT_W'(rate_ticks(code) - 1);
  assign per_evt = run && tick && !restart && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || restart || per_evt)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last)); // R4

  AST_EVT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> !per_evt); // R4

endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
  import rtc_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_per,
  input  logic       set_alm,
  input  logic       set_upd,
  input  logic       rd_clr,
  input  logic [2:0] en,
  output logic [2:0] flags,
  output logic       irqf
);

  logic [2:0] flags_q;
  logic [2:0] flags_d;
  logic [2:0] set_vec;
  logic       irqf_q;

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_PER] = set_per;
    set_vec[FLG_ALM] = set_alm;
    set_vec[FLG_UPD] = set_upd;
    flags_d          = (rd_clr ? 3'b000 : flags_q) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irqf_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irqf_q  <= |(flags_d & en);
    end
  end

  assign flags = flags_q;
  assign irqf  = irqf_q;

  AST_ALARM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    set_alm |=> flags_q[FLG_ALM]); // R9

  AST_UPD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_upd |=> flags_q[FLG_UPD]); // R6

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_per && !set_alm && !set_upd) |=> (flags_q == 3'b000 && !irqf_q)); // R8

  AST_IRQF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && |(flags_q & en)) |=> irqf_q); // R7

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       upd_busy,
  input  logic       alarm_hit,
  input  logic       update_done,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic       data_rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);

  logic [3:0] idx_q;
  logic [6:0] ctl_a_q;
  logic [7:0] ctl_b_q;
  logic       wr_a, wr_b, rd_clr;
  logic       div_run, per_evt, irqf;
  logic [2:0] flags;

  assign wr_a    = data_wr && (idx_q == IDX_CTL_A);
  assign wr_b    = data_wr && (idx_q == IDX_CTL_B);
  assign rd_clr  = data_rd && (idx_q == IDX_STAT);
  assign div_run = (ctl_a_q[6:4] == DIV_RUN_32K) && (ctl_a_q[3:0] != 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      ctl_a_q <= '0;
      ctl_b_q <= '0;
    end else begin
      if (idx_wr) idx_q   <= wdata[3:0];
      if (wr_a)   ctl_a_q <= wdata[6:0];
      if (wr_b)   ctl_b_q <= wdata;
    end
  end

  rtc_rate_div #(.CNT_W(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (div_run),
    .restart (wr_a),
    .tick    (tick_32k),
    .code    (ctl_a_q[3:0]),
    .per_evt (per_evt)
  );

  rtc_flag_unit u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_per (per_evt),
    .set_alm (alarm_hit),
    .set_upd (update_done),
    .rd_clr  (rd_clr),
    .en      (ctl_b_q[6:4]),
    .flags   (flags),
    .irqf    (irqf)
  );

  always_comb begin
    unique case (idx_q)
      IDX_CTL_A: rdata = {upd_busy, ctl_a_q};
      IDX_CTL_B: rdata = ctl_b_q;
      IDX_STAT:  rdata = {irqf, flags, 4'b0000};
      IDX_PWR:   rdata = PWR_OK_VAL;
      default:   rdata = 8'h00;
    endcase
  end

  assign irq = irqf;

  AST_BUSY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == IDX_CTL_A) |-> (rdata[7] == upd_busy)); // R2

  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_b |=> $stable(ctl_b_q)); // R3

  AST_PER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !div_run |-> !per_evt); // R5

  AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == IDX_STAT) |-> (rdata[3:0] == 4'h0)); // R8

endmodule

// File: tb/tb_rtc_irq_ctrl.sv
module tb_rtc_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0, upd_busy = 1'b0, alarm_hit = 1'b0, update_done = 1'b0;
  logic       idx_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .upd_busy(upd_busy),
    .alarm_hit(alarm_hit), .update_done(update_done), .idx_wr(idx_wr),
    .data_wr(data_wr), .data_rd(data_rd), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_a, m_b, m_idx, m_cnt;
  bit m_pf, m_af, m_uf, m_irqf;

  function automatic int period_of(input int code);
    int p = 1;
    int k = (code < 3) ? code + 6 : code - 1;
    for (int i = 0; i < k; i++) p = p * 2;
    return p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_idx = 0; m_cnt = 0;
      m_pf = 0; m_af = 0; m_uf = 0; m_irqf = 0;
    end else begin
      bit clr, rst_cnt, running, pev;
      clr     = data_rd && (m_idx == 12);
      rst_cnt = data_wr && (m_idx == 10);
      running = ((m_a / 16) == 2) && ((m_a % 16) != 0);
      pev     = 0;
      if (!running || rst_cnt) m_cnt = 0;
      else if (tick_32k) begin
        if (m_cnt + 1 == period_of(m_a % 16)) begin pev = 1; m_cnt = 0; end
        else m_cnt++;
      end
      if (clr) begin m_pf = 0; m_af = 0; m_uf = 0; end
      if (pev) m_pf = 1;
      if (alarm_hit) m_af = 1;
      if (update_done) m_uf = 1;
      m_irqf = (m_pf && m_b[6]) || (m_af && m_b[5]) || (m_uf && m_b[4]);
      if (idx_wr) m_idx = wdata % 16;
      if (data_wr && m_idx == 10) m_a = wdata % 128;
      if (data_wr && m_idx == 11) m_b = wdata;
    end
  end

  function automatic logic [7:0] model_rdata();
    case (m_idx)
      10: return {upd_busy, 7'(m_a)};
      11: return 8'(m_b);
      12: return {m_irqf, m_pf, m_af, m_uf, 4'b0000};
      13: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 model rdata", int'(rdata), int'(model_rdata()));
      chk("R7 model irq", int'(irq), int'(m_irqf));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic write_reg(input logic [3:0] idx, input logic [7:0] val);
    step(); idx_wr = 1; wdata = {4'h0, idx};
    step(); idx_wr = 0; data_wr = 1; wdata = val;
    step(); data_wr = 0;
  endtask

  task automatic read_reg(input logic [3:0] idx, output logic [7:0] val);
    step(); idx_wr = 1; wdata = {4'h0, idx};
    step(); idx_wr = 0; data_rd = 1;
    @(negedge clk); val = rdata;
    step(); data_rd = 0;
  endtask

  task automatic ticks(input int n, input bit fast);
    if (fast) begin
      step(); tick_32k = 1; repeat (n) step(); tick_32k = 0;
    end else begin
      for (int i = 0; i < n; i++) begin step(); tick_32k = 1; step(); tick_32k = 0; end
    end
  endtask

  task automatic irq_is(input string req, input bit exp);
    @(negedge clk);
    chk(req, int'(irq), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk); #2 rst_n = 1;

    // R1 reset state
    irq_is("R1 irq", 0);
    read_reg(4'hA, v); chk("R1 reg A", v, 8'h00);
    read_reg(4'hB, v); chk("R1 reg B", v, 8'h00);
    read_reg(4'hC, v); chk("R1 reg C", v, 8'h00);
    read_reg(4'hD, v); chk("R1 reg D", v, 8'h80);

    // R2 register A and busy mirror
    write_reg(4'hA, 8'hA6);
    read_reg(4'hA, v); chk("R2 bit7 ignored", v, 8'h26);
    upd_busy = 1;
    read_reg(4'hA, v); chk("R2 busy mirror", v, 8'hA6);
    upd_busy = 0;

    // R3 register B
    write_reg(4'hB, 8'h5A);
    read_reg(4'hB, v); chk("R3 B readback", v, 8'h5A);
    write_reg(4'hB, 8'h40);
    read_reg(4'hC, v);

    // R4 code 3: 4 ticks
    write_reg(4'hA, 8'h23);
    ticks(3, 0); irq_is("R4 code3 early", 0);
    ticks(1, 0); irq_is("R4 code3 edge", 1);
    read_reg(4'hC, v); chk("R8 read flags", v, 8'hC0);
    irq_is("R8 irq cleared", 0);

    // R4 code 1: 128 ticks
    write_reg(4'hA, 8'h21);
    ticks(127, 1); irq_is("R4 code1 early", 0);
    ticks(1, 1);   irq_is("R4 code1 edge", 1);
    read_reg(4'hC, v); chk("R4 code1 flags", v, 8'hC0);

    // R4 code 15: 16384 ticks
    write_reg(4'hA, 8'h2F);
    ticks(16383, 1); irq_is("R4 code15 early", 0);
    ticks(1, 1);     irq_is("R4 code15 edge", 1);
    read_reg(4'hC, v); chk("R4 code15 flags", v, 8'hC0);

    // R5 divider off / rate zero
    write_reg(4'hA, 8'h33);
    ticks(50, 1);
    read_reg(4'hC, v); chk("R5 divider off", v, 8'h00);
    write_reg(4'hA, 8'h20);
    ticks(50, 1);
    read_reg(4'hC, v); chk("R5 rate zero", v, 8'h00);

    // R6 flags without enables
    write_reg(4'hB, 8'h00);
    step(); alarm_hit = 1; step(); alarm_hit = 0;
    irq_is("R6 no enable no irq", 0);
    read_reg(4'hC, v); chk("R6 alarm flag", v, 8'h20);
    write_reg(4'hB, 8'h10);
    step(); update_done = 1; step(); update_done = 0;
    irq_is("R7 update irq", 1);
    read_reg(4'hC, v); chk("R6 update flag", v, 8'h90);

    // R7 enable after flag
    write_reg(4'hB, 8'h00);
    step(); alarm_hit = 1; step(); alarm_hit = 0;
    irq_is("R7 still low", 0);
    write_reg(4'hB, 8'h20);
    step(); irq_is("R7 late enable", 1);
    read_reg(4'hC, v); chk("R7 summary bit", v, 8'hA0);

    // R9 event during clearing read
    step(); idx_wr = 1; wdata = 8'h0C;
    step(); idx_wr = 0; data_rd = 1; alarm_hit = 1;
    step(); data_rd = 0; alarm_hit = 0;
    irq_is("R9 irq kept", 1);
    read_reg(4'hC, v); chk("R9 flag kept", v, 8'hA0);

    // R10 read-only locations
    write_reg(4'hC, 8'hFF);
    write_reg(4'hD, 8'h00);
    irq_is("R10 irq unchanged", 0);
    read_reg(4'hC, v); chk("R10 reg C", v, 8'h00);
    read_reg(4'hD, v); chk("R10 reg D", v, 8'h80);
    read_reg(4'hB, v); chk("R10 reg B kept", v, 8'h20);

    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule